// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a way into a 64K-word internal register space through only two host-visible words. One is a command word. The other is a data word. The host selects one of them with `h_sel` and strobes `h_wr` or `h_rd` for one clock cycle. A command word with its start flag set launches one access on the internal bus. That bus uses a request/acknowledge handshake. The start flag reads back as 1 until the access completes, and the host polls it to learn when the access is done.

- **Writes:** the host loads the data word first. It then issues a command with the direction flag clear.
- **Reads:** the result lands in the data word when the start flag drops.
- **Sequential reads:** the command can request automatic stepping. Each host read of the data word then moves the stored address up or down by one, wrapping at the ends of the range, and launches the next read with no new command.
- **Ending a stepping run:** before its last data read, the host stops the chain by writing a command with the start flag and the stepping bits clear.

Top module: `regbridge`

## Requirements
- R1: After reset the command word reads 0, the data word reads 0 and `ib_req` is low.
- R2: The command word (`h_sel`=0) holds these fields. Bits 27:16 always read 0.
  - bit 31: busy/start flag
  - bit 30: read-not-write
  - bit 29: step up
  - bit 28: step down
  - bits 15:0: register address

  The data word is selected with `h_sel`=1.
- R3: A command write with bit 31 set, made while idle, makes bit 31 read 1 and `ib_req` go high on the very next cycle.
- R4: For a read command, `ib_we` is 0 and `ib_addr` is the command address. The data word takes `ib_rdata` on the cycle where `ib_ack` meets `ib_req`, and busy clears on that same edge.
- R5: For a write command, `ib_we` is 1 and `ib_wdata` is the previously loaded data word. Busy clears on acknowledge.
- R6: Once `ib_req` is high, it stays high with `ib_addr`, `ib_we` and `ib_wdata` unchanged until `ib_ack` is seen.
- R7: Suppose the bridge is idle after a read command with step up set. A host read of the data word then returns the current data, adds one to the stored address and starts a new read.
- R8: With only step down set, the data read subtracts one instead. With both stepping bits set, the bridge steps up.
- R9: Address stepping wraps modulo 2^16: 0xFFFF steps up to 0x0000, and 0x0000 steps down to 0xFFFF.
- R10: While busy is 1, host writes to either word have no effect, and host reads of the data word start nothing.
- R11: A command write with bit 31 clear only updates the fields and starts no access. A data read starts no access if both stepping bits are clear or if the direction is write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_sel | input | 1 | Host word select: 0 command, 1 data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects on the data word only) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Contents of the selected word |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | 16 | Internal bus address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal bus read data |

## Verification
Busy and `ib_req` are due one cycle after a starting command write or a stepping data read. The bench therefore samples them at the next falling edge. The stepped address is due in that same cycle.

Completion depends on the randomized bus latency. For that reason the read data and the cleared busy flag are checked only after the bench has seen bit 31 read 0. The bench allows at most 16 cycles for this, and a longer wait fails the check.

Writes and reads made while busy are checked after completion through the host words. The end of a stepping run is checked by confirming that `ib_req` stays low on the cycle after the final read.

// File: rtl/regbridge.sv
module regbridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        ib_req,
  output logic        ib_we,
  output logic [15:0] ib_addr,
  output logic [31:0] ib_wdata,
  input  logic        ib_ack,
  input  logic [31:0] ib_rdata
);
  localparam int BUSY_B = 31;
  localparam int RNW_B  = 30;
  localparam int UP_B   = 29;
  localparam int DN_B   = 28;

  logic        busy_q, rnw_q, up_q, dn_q, req_q, we_q;
  logic [15:0] addr_q;
  logic [31:0] data_q;

  logic idle, cmd_wr, dat_wr, step_rd, done;
  logic [15:0] step_addr;

  assign idle      = !busy_q;
  assign cmd_wr    = idle && h_wr && !h_sel;
  assign dat_wr    = idle && h_wr && h_sel;
  assign step_rd   = idle && h_rd && !h_wr && h_sel && rnw_q && (up_q || dn_q);
  assign done      = req_q && ib_ack;
  assign step_addr = up_q ? addr_q + 16'd1 : addr_q - 16'd1;

  assign h_rdata  = h_sel ? data_q : {busy_q, rnw_q, up_q, dn_q, 12'd0, addr_q};
  assign ib_req   = req_q;
  assign ib_we    = we_q;
  assign ib_addr  = addr_q;
  assign ib_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnw_q  <= 1'b0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= 16'd0;
      data_q <= 32'd0;
    end else if (done) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      if (!we_q) data_q <= ib_rdata;
    end else if (cmd_wr) begin
      busy_q <= h_wdata[BUSY_B];
      req_q  <= h_wdata[BUSY_B];
      rnw_q  <= h_wdata[RNW_B];
      we_q   <= !h_wdata[RNW_B];
      up_q   <= h_wdata[UP_B];
      dn_q   <= h_wdata[DN_B];
      addr_q <= h_wdata[15:0];
    end else if (dat_wr) begin
      data_q <= h_wdata;
    end else if (step_rd) begin
      addr_q <= step_addr;
      busy_q <= 1'b1;
      req_q  <= 1'b1;
      we_q   <= 1'b0;
    end
  end
endmodule

module regbridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_sel,
  input logic        h_wr,
  input logic        h_rd,
  input logic [31:0] h_wdata,
  input logic        ib_req,
  input logic        ib_we,
  input logic [15:0] ib_addr,
  input logic [31:0] ib_wdata,
  input logic        ib_ack,
  input logic        busy_q,
  input logic        rnw_q,
  input logic        up_q,
  input logic        dn_q,
  input logic [31:0] data_q
);
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_sel && h_wdata[31] && !busy_q) |=> (busy_q && ib_req));

  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_ack) |=> (!busy_q && !ib_req));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

  a_r10_ignore_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && h_wr && !(ib_req && ib_ack)) |=> $stable(data_q));

  a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && h_rd && !h_wr && h_sel && rnw_q && up_q)
      |=> (ib_req && !ib_we && ib_addr == $past(ib_addr) + 16'd1));

  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && h_rd && !h_wr && h_sel && rnw_q && dn_q && !up_q)
      |=> (ib_req && ib_addr == $past(ib_addr) - 16'd1));

  a_r11_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ib_req) |-> !$past(busy_q));

  a_r4_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> busy_q);
endmodule

bind regbridge regbridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
  .h_wdata(h_wdata), .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
  .ib_wdata(ib_wdata), .ib_ack(ib_ack), .busy_q(busy_q), .rnw_q(rnw_q),
  .up_q(up_q), .dn_q(dn_q), .data_q(data_q)
);

// File: tb/regbridge_tb.sv
module regbridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
  logic [31:0] h_wdata = 32'd0;
  logic [31:0] h_rdata;
  logic        ib_req, ib_we, ib_ack;
  logic [15:0] ib_addr;
  logic [31:0] ib_wdata, ib_rdata;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  regbridge u_dut (.*);

  // internal register file model, latency 1..8 cycles
  logic [31:0] mem [256];
  logic [2:0]  lat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_ack   <= 1'b0;
      ib_rdata <= 32'd0;
      lat      <= 3'd0;
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i[7:0]);
    end else begin
      ib_ack <= 1'b0;
      if (ib_req && !ib_ack) begin
        if (lat == 3'd0) begin
          ib_ack   <= 1'b1;
          ib_rdata <= mem[ib_addr[7:0]];
          if (ib_we) mem[ib_addr[7:0]] <= ib_wdata;
          lat <= 3'($urandom % 8);
        end else lat <= lat - 3'd1;
      end
    end
  end

  function automatic logic [31:0] init_val(input logic [7:0] a);
    return {8'hC0, a, ~a, 8'h3D};
  endfunction

  logic [31:0] shadow [256];

  function automatic logic [31:0] cmd(input bit go, input bit rnw, input bit up,
                                      input bit dn, input logic [15:0] a);
    return {go, rnw, up, dn, 12'd0, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input bit sel, input logic [31:0] v);
    @(negedge clk); h_sel = sel; h_wdata = v; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(input bit sel, output logic [31:0] v);
    @(negedge clk); h_sel = sel; h_rd = 1'b1; #1 v = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic peek(input bit sel, output logic [31:0] v);
    h_sel = sel; #1 v = h_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] c;
    int k = 0;
    peek(1'b0, c);
    while (c[31] && k < 16) begin
      @(negedge clk); peek(1'b0, c); k++;
    end
    chk(!c[31], tag, c, {1'b0, c[30:0]});
  endtask

  task automatic single_read(input logic [15:0] a, input string tag);
    logic [31:0] v;
    hwrite(1'b0, cmd(1, 1, 0, 0, a));
    wait_idle(tag);
    peek(1'b1, v);
    chk(v == shadow[a[7:0]], tag, v, shadow[a[7:0]]);
  endtask

  task automatic single_write(input logic [15:0] a, input logic [31:0] d, input string tag);
    hwrite(1'b1, d);
    hwrite(1'b0, cmd(1, 0, 0, 0, a));
    wait_idle(tag);
    shadow[a[7:0]] = d;
  endtask

  // stepping run of n reads from a; dir 1 up, 0 down, both=1 sets both bits
  task automatic run_reads(input logic [15:0] a, input int n, input bit dir, input bit both, input string tag);
    logic [31:0] v, c;
    logic [15:0] cur = a;
    hwrite(1'b0, cmd(1, 1, dir | both, !dir | both, a));
    wait_idle(tag);
    for (int i = 0; i < n - 1; i++) begin
      hread(1'b1, v);
      chk(v == shadow[cur[7:0]], tag, v, shadow[cur[7:0]]);
      cur = (dir | both) ? cur + 16'd1 : cur - 16'd1;
      peek(1'b0, c);
      chk(c[31] && c[15:0] == cur, tag, c, {1'b1, c[30:16], cur});
      wait_idle(tag);
    end
    hwrite(1'b0, cmd(0, 1, 0, 0, cur));
    hread(1'b1, v);
    chk(v == shadow[cur[7:0]], tag, v, shadow[cur[7:0]]);
    chk(!ib_req, "R11 final read starts nothing", {31'd0, ib_req}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240));
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i[7:0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(1'b0, v); chk(v == 32'd0, "R1 cmd reset", v, 32'd0);
    peek(1'b1, v); chk(v == 32'd0, "R1 data reset", v, 32'd0);
    chk(!ib_req, "R1 req reset", {31'd0, ib_req}, 32'd0);

    hwrite(1'b0, 32'h3FFF_1234);
    peek(1'b0, v); chk(v == 32'h3000_1234, "R2 field layout", v, 32'h3000_1234);
    chk(!ib_req, "R11 no access without start", {31'd0, ib_req}, 32'd0);

    @(negedge clk); h_sel = 1'b0; h_wdata = cmd(1, 1, 0, 0, 16'h0042); h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
    peek(1'b0, v);
    chk(v[31] && ib_req && !ib_we && ib_addr == 16'h0042, "R3/R4 start read", v, cmd(1, 1, 0, 0, 16'h0042));
    wait_idle("R4 read done");
    peek(1'b1, v); chk(v == shadow[8'h42], "R4 read data", v, shadow[8'h42]);

    hwrite(1'b1, 32'hDEAD_BEEF);
    @(negedge clk); h_sel = 1'b0; h_wdata = cmd(1, 0, 0, 0, 16'h0010); h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
    chk(ib_req && ib_we && ib_wdata == 32'hDEAD_BEEF, "R5 write drive", ib_wdata, 32'hDEAD_BEEF);
    wait_idle("R5 write done");
    shadow[8'h10] = 32'hDEAD_BEEF;
    single_read(16'h0010, "R5 write readback");

    hwrite(1'b0, cmd(1, 1, 0, 0, 16'h0020));
    @(negedge clk); h_sel = 1'b1; h_wdata = 32'h1111_1111; h_wr = 1'b1;
    @(negedge clk); h_sel = 1'b0; h_wdata = cmd(1, 1, 0, 0, 16'h0077);
    @(negedge clk); h_wr = 1'b0;
    wait_idle("R10 busy ignore");
    peek(1'b1, v); chk(v == shadow[8'h20], "R10 data write ignored", v, shadow[8'h20]);
    peek(1'b0, v); chk(v[15:0] == 16'h0020, "R10 cmd write ignored", v, cmd(0, 1, 0, 0, 16'h0020));

    hwrite(1'b0, cmd(1, 1, 1, 0, 16'h0030));
    hread(1'b1, v);
    wait_idle("R10 read while busy");
    peek(1'b0, v); chk(v[15:0] == 16'h0030, "R10 read while busy no step", v, cmd(0, 1, 1, 0, 16'h0030));

    run_reads(16'h0050, 4, 1'b1, 1'b0, "R7 step up");
    run_reads(16'h0060, 4, 1'b0, 1'b0, "R8 step down");
    run_reads(16'h0070, 3, 1'b1, 1'b1, "R8 both bits step up");
    run_reads(16'hFFFE, 4, 1'b1, 1'b0, "R9 wrap up");
    run_reads(16'h0001, 4, 1'b0, 1'b0, "R9 wrap down");

    hwrite(1'b0, cmd(0, 0, 1, 0, 16'h0005));
    hread(1'b1, v);
    chk(!ib_req, "R11 write dir no step", {31'd0, ib_req}, 32'd0);

    for (int i = 0; i < 60; i++) begin
      logic [15:0] a = 16'($urandom % 256);
      if ($urandom % 2) single_write(a, $urandom, "R5 random write");
      else single_read(a, "R4 random read");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule